// File: doc/BRIEF.md
# Query Release and Conditional Render Unit

This unit serves two kinds of command that a front-end writes into its small register file. A query command either raises a semaphore strobe at a programmed address or stores a result to memory. The result is one 32-bit word, or a 16-byte record made of a 64-bit value and a 64-bit timestamp. A condition command sets an execute-enable flag. Some condition modes set the flag at once. The others first fetch a four-word compare record from memory and derive the flag from it.

Downstream draw logic presents requests on `draw_req_i`. While a compare record is being fetched, `draw_ready_o` is low, so draws stall until the flag is valid. An accepted draw runs only if `execute_on_o` is high. One request port is shared by the writes and the reads, and only one command is in flight at a time.

Register indices on `cfg_addr_i` are 0 query address, 1 query sequence, 2 query command (trigger), 3 compare-record address and 4 condition mode (trigger). The query command word carries the operation in bits [1:0] (0 release, 1 acquire, 2 counter, 3 trap), fence in bit 4, short format in bit 5 and the counter select in bits [11:8]. The condition mode in bits [2:0] is one of 0 never, 1 always, 2 result-non-zero, 3 equal or 4 not-equal. Values 5 to 7 are unrecognised.

Top module: `query_cond_unit`

## Requirements
- R1: After reset `execute_on_o` is 1, `draw_ready_o` is 1, and `mem_req_valid_o` and `sem_valid_o` are 0.
- R2: A release command with fence=1 drives `sem_valid_o` high for exactly the one cycle after the command write. During that cycle `sem_addr_o` holds the query address and `sem_payload_o` holds the sequence. No memory write is issued.
- R3: A release command with fence=0 and short=1 issues one write of the sequence word to the query address.
- R4: With short=0, four word writes go to the query address +0, +4, +8 and +12. Their data is the value's low word, the value's high word (0), the timestamp low word and the timestamp high word. The timestamp is the one sampled at the clock edge that takes the command write.
- R5: A counter command with select 0 stores the value 0; any other select stores 1. The format follows the short bit as in R3 and R4.
- R6: Acquire and trap commands produce no memory request and no semaphore strobe.
- R7: Mode always sets `execute_on_o` to 1 and mode never sets it to 0. Both take effect at the edge that takes the write, with no memory read.
- R8: The memory modes read four words from the record address +0, +4, +8 and +12, in that order. The words are the initial sequence, the initial mode, the current sequence and the current mode.
- R9: Result-non-zero mode enables execution only when the initial sequence and the initial mode are both non-zero.
- R10: Equal mode enables execution when both initial fields match their current fields. Not-equal mode gives the exact inverse.
- R11: Unrecognised modes 5 to 7 enable execution.
- R12: `draw_ready_o` is low while a compare record is being fetched. `draw_run_o` equals `draw_req_i` and `draw_ready_o` and `execute_on_o`.
- R13: A write to either trigger register while any command is in flight is ignored.
- R14: A memory request held while `mem_req_ready_i` is low keeps its address, data and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| timestamp_i | input | 64 | Free-running time count |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | ADDR_W | Byte address of the word |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 32 | Read data |
| sem_valid_o | output | 1 | Semaphore strobe |
| sem_addr_o | output | ADDR_W | Semaphore address |
| sem_payload_o | output | 32 | Semaphore payload |
| draw_req_i | input | 1 | Draw request |
| draw_ready_o | output | 1 | Draw may be accepted |
| draw_run_o | output | 1 | Accepted draw executes |
| execute_on_o | output | 1 | Execute-enable flag |

## Verification
The bench builds the unit with the default ADDR_W of 32, which lets record and query addresses be written directly as 32-bit register values. The bench's memory model folds addresses onto 64 words. During the long-record test it stalls the request port on alternate cycles, which exercises the hold-while-not-ready behaviour. The sequence of condition modes is ordered so that every result flips the flag from its previous value. As a result, a mode that leaves the flag untouched is caught.

// File: rtl/qc_pkg.sv
// qc_pkg: shared constants, compare-record type and the predicate function
// for the query/condition unit. Assumes 32-bit record words and a 64-bit
// timestamp.
package qc_pkg;
    localparam int WORD_W  = 32;
    localparam int TS_W    = 64;
    localparam int REC_W   = 2 * WORD_W + TS_W;
    localparam int CFG_AW  = 3;

    // register indices
    localparam logic [CFG_AW-1:0] RG_QADDR = 3'd0;
    localparam logic [CFG_AW-1:0] RG_QSEQ  = 3'd1;
    localparam logic [CFG_AW-1:0] RG_QCMD  = 3'd2;
    localparam logic [CFG_AW-1:0] RG_CADDR = 3'd3;
    localparam logic [CFG_AW-1:0] RG_CMODE = 3'd4;

    // query operations
    localparam logic [1:0] OP_RELEASE = 2'd0;
    localparam logic [1:0] OP_ACQUIRE = 2'd1;
    localparam logic [1:0] OP_COUNTER = 2'd2;
    localparam logic [1:0] OP_TRAP    = 2'd3;
    localparam logic [3:0] SEL_ZERO   = 4'd0;

    // condition modes
    localparam logic [2:0] CM_NEVER  = 3'd0;
    localparam logic [2:0] CM_ALWAYS = 3'd1;
    localparam logic [2:0] CM_RES_NZ = 3'd2;
    localparam logic [2:0] CM_EQUAL  = 3'd3;
    localparam logic [2:0] CM_NEQUAL = 3'd4;

    typedef struct packed {
        logic [WORD_W-1:0] init_seq;
        logic [WORD_W-1:0] init_mode;
        logic [WORD_W-1:0] cur_seq;
        logic [WORD_W-1:0] cur_mode;
    } cmp_rec_t;

    // True when the mode needs the compare record from memory.
    function automatic logic qc_mode_reads(input logic [2:0] mode);
        return (mode == CM_RES_NZ) || (mode == CM_EQUAL) || (mode == CM_NEQUAL);
    endfunction

    // Execute-enable decision for a mode and a compare record.
    function automatic logic qc_decide(input logic [2:0] mode, input cmp_rec_t r);
        logic same;
        same = (r.init_seq == r.cur_seq) && (r.init_mode == r.cur_mode);
        case (mode)
            CM_NEVER:  return 1'b0;
            CM_RES_NZ: return (r.init_seq != '0) && (r.init_mode != '0);
            CM_EQUAL:  return same;
            CM_NEQUAL: return !same;
            default:   return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/qc_query_writer.sv
// qc_query_writer: executes one query command. It raises a one-cycle
// semaphore strobe, or it streams a 1-word or 4-word result record to the
// write port. Assumes start_i is given only while busy_o is low.
module qc_query_writer
    import qc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              fence_i,
    input  logic              short_i,
    input  logic [3:0]        sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] seq_i,
    input  logic [TS_W-1:0]   ts_i,
    output logic              busy_o,
    output logic              sem_valid_o,
    output logic [ADDR_W-1:0] sem_addr_o,
    output logic [WORD_W-1:0] sem_payload_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ready_i
);
    typedef enum logic [1:0] {W_IDLE, W_SEM, W_WRITE} wstate_e;

    wstate_e           state_q;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] seq_q;
    logic [REC_W-1:0]  rec_q;
    logic [1:0]        idx_q;
    logic [1:0]        last_q;
    logic [WORD_W-1:0] value_c;
    logic              do_sem_c;
    logic              do_write_c;

    // Decode the command into an action and a result value.
    always_comb begin
        do_sem_c   = 1'b0;
        do_write_c = 1'b0;
        value_c    = seq_i;
        case (op_i)
            OP_RELEASE: begin
                if (fence_i) do_sem_c = 1'b1;
                else         do_write_c = 1'b1;
            end
            OP_COUNTER: begin
                do_write_c = 1'b1;
                value_c    = (sel_i == SEL_ZERO) ? '0 : WORD_W'(1);
            end
            default: ;
        endcase
    end

    // Command sequencer: latch on start, strobe or stream words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            base_q  <= '0;
            seq_q   <= '0;
            rec_q   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
        end else begin
            case (state_q)
                W_IDLE: begin
                    if (start_i) begin
                        base_q <= addr_i;
                        seq_q  <= seq_i;
                        idx_q  <= '0;
                        last_q <= short_i ? 2'd0 : 2'd3;
                        rec_q  <= {ts_i, {WORD_W{1'b0}}, value_c};
                        if (do_sem_c)        state_q <= W_SEM;
                        else if (do_write_c) state_q <= W_WRITE;
                    end
                end
                W_SEM: state_q <= W_IDLE;
                W_WRITE: begin
                    if (wr_ready_i) begin
                        if (idx_q == last_q) state_q <= W_IDLE;
                        else                 idx_q   <= idx_q + 2'd1;
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign busy_o        = (state_q != W_IDLE);
    assign sem_valid_o   = (state_q == W_SEM);
    assign sem_addr_o    = base_q;
    assign sem_payload_o = seq_q;
    assign wr_valid_o    = (state_q == W_WRITE);
    assign wr_addr_o     = base_q + ADDR_W'({idx_q, 2'b00});
    assign wr_data_o     = rec_q[{idx_q, 5'd0} +: WORD_W];
endmodule

// File: rtl/qc_cond_eval.sv
// qc_cond_eval: owns the execute-enable flag. Immediate modes update it on
// the start edge. Memory modes fetch four record words one at a time and
// update the flag on the last response. Assumes one read is outstanding.
module qc_cond_eval
    import qc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              busy_o,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ready_i,
    input  logic              rsp_valid_i,
    input  logic [WORD_W-1:0] rsp_data_i,
    output logic              execute_on_o
);
    typedef enum logic [1:0] {C_IDLE, C_REQ, C_WAIT} cstate_e;

    cstate_e           state_q;
    logic [2:0]        mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        idx_q;
    logic [WORD_W-1:0] w0_q, w1_q, w2_q;
    logic              exec_q;
    cmp_rec_t          rec_c;

    // Assemble the record with the final word taken from the response.
    always_comb begin
        rec_c.init_seq  = w0_q;
        rec_c.init_mode = w1_q;
        rec_c.cur_seq   = w2_q;
        rec_c.cur_mode  = rsp_data_i;
    end

    // Fetch sequencer and flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
            mode_q  <= CM_ALWAYS;
            base_q  <= '0;
            idx_q   <= '0;
            w0_q    <= '0;
            w1_q    <= '0;
            w2_q    <= '0;
            exec_q  <= 1'b1;
        end else begin
            case (state_q)
                C_IDLE: begin
                    if (start_i) begin
                        mode_q <= mode_i;
                        base_q <= base_i;
                        idx_q  <= '0;
                        if (qc_mode_reads(mode_i)) state_q <= C_REQ;
                        else                       exec_q  <= qc_decide(mode_i, '0);
                    end
                end
                C_REQ: if (rd_ready_i) state_q <= C_WAIT;
                C_WAIT: begin
                    if (rsp_valid_i) begin
                        case (idx_q)
                            2'd0: w0_q <= rsp_data_i;
                            2'd1: w1_q <= rsp_data_i;
                            2'd2: w2_q <= rsp_data_i;
                            default: exec_q <= qc_decide(mode_q, rec_c);
                        endcase
                        if (idx_q == 2'd3) state_q <= C_IDLE;
                        else begin
                            idx_q   <= idx_q + 2'd1;
                            state_q <= C_REQ;
                        end
                    end
                end
                default: state_q <= C_IDLE;
            endcase
        end
    end

    assign busy_o       = (state_q != C_IDLE);
    assign rd_valid_o   = (state_q == C_REQ);
    assign rd_addr_o    = base_q + ADDR_W'({idx_q, 2'b00});
    assign execute_on_o = exec_q;
endmodule

// File: rtl/query_cond_unit.sv
// query_cond_unit: register file, trigger gating, memory port sharing and
// draw gating around the query writer and the condition evaluator.
// Assumes ADDR_W <= 32 (addresses come from one register write).
module query_cond_unit
    import qc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    input  logic [TS_W-1:0]   timestamp_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic              mem_req_write_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic [WORD_W-1:0] mem_req_wdata_o,
    input  logic              mem_rsp_valid_i,
    input  logic [WORD_W-1:0] mem_rsp_rdata_i,
    output logic              sem_valid_o,
    output logic [ADDR_W-1:0] sem_addr_o,
    output logic [WORD_W-1:0] sem_payload_o,
    input  logic              draw_req_i,
    output logic              draw_ready_o,
    output logic              draw_run_o,
    output logic              execute_on_o
);
    logic [ADDR_W-1:0] qaddr_q, caddr_q;
    logic [WORD_W-1:0] qseq_q;
    logic              w_busy, c_busy, idle_c;
    logic              q_start, c_start;
    logic              w_valid, r_valid;
    logic [ADDR_W-1:0] w_addr, r_addr;
    logic [WORD_W-1:0] w_data;

    // Plain registers; always writable since the engines keep copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qaddr_q <= '0;
            qseq_q  <= '0;
            caddr_q <= '0;
        end else if (cfg_we_i) begin
            if (cfg_addr_i == RG_QADDR) qaddr_q <= cfg_wdata_i[ADDR_W-1:0];
            if (cfg_addr_i == RG_QSEQ)  qseq_q  <= cfg_wdata_i;
            if (cfg_addr_i == RG_CADDR) caddr_q <= cfg_wdata_i[ADDR_W-1:0];
        end
    end

    // Triggers are accepted only when nothing is in flight.
    assign idle_c  = !w_busy && !c_busy;
    assign q_start = cfg_we_i && (cfg_addr_i == RG_QCMD)  && idle_c;
    assign c_start = cfg_we_i && (cfg_addr_i == RG_CMODE) && idle_c;

    qc_query_writer #(.ADDR_W(ADDR_W)) writer_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (q_start),
        .op_i          (cfg_wdata_i[1:0]),
        .fence_i       (cfg_wdata_i[4]),
        .short_i       (cfg_wdata_i[5]),
        .sel_i         (cfg_wdata_i[11:8]),
        .addr_i        (qaddr_q),
        .seq_i         (qseq_q),
        .ts_i          (timestamp_i),
        .busy_o        (w_busy),
        .sem_valid_o   (sem_valid_o),
        .sem_addr_o    (sem_addr_o),
        .sem_payload_o (sem_payload_o),
        .wr_valid_o    (w_valid),
        .wr_addr_o     (w_addr),
        .wr_data_o     (w_data),
        .wr_ready_i    (mem_req_ready_i)
    );

    qc_cond_eval #(.ADDR_W(ADDR_W)) cond_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (c_start),
        .mode_i       (cfg_wdata_i[2:0]),
        .base_i       (caddr_q),
        .busy_o       (c_busy),
        .rd_valid_o   (r_valid),
        .rd_addr_o    (r_addr),
        .rd_ready_i   (mem_req_ready_i),
        .rsp_valid_i  (mem_rsp_valid_i),
        .rsp_data_i   (mem_rsp_rdata_i),
        .execute_on_o (execute_on_o)
    );

    // Share the request port; the two engines never run together.
    assign mem_req_valid_o = w_valid || r_valid;
    assign mem_req_write_o = w_valid;
    assign mem_req_addr_o  = w_valid ? w_addr : r_addr;
    assign mem_req_wdata_o = w_valid ? w_data : '0;

    // Stall draws during a record fetch; gate accepted draws by the flag.
    assign draw_ready_o = !c_busy;
    assign draw_run_o   = draw_req_i && draw_ready_o && execute_on_o;
endmodule

// File: rtl/query_cond_unit_chk.sv
// query_cond_unit_chk: port-level properties of query_cond_unit, bound to
// every instance of it.
module query_cond_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we_i,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic              mem_req_write_o,
    input logic [ADDR_W-1:0] mem_req_addr_o,
    input logic [31:0]       mem_req_wdata_o,
    input logic              mem_rsp_valid_i,
    input logic              sem_valid_o,
    input logic              draw_ready_o,
    input logic              draw_run_o,
    input logic              execute_on_o
);
    // R2: no memory traffic in the cycle of a semaphore strobe
    p_sem_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sem_valid_o |-> !mem_req_valid_o);

    // R2: the strobe lasts a single cycle
    p_sem_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sem_valid_o |=> !sem_valid_o);

    // R14: a stalled request holds steady
    p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=>
        (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_wdata_o)
         && $stable(mem_req_write_o)));

    // R12: a pending record read keeps draws stalled
    p_read_stalls_draw_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_write_o) |-> !draw_ready_o);

    // R12: a running draw implies the flag is set
    p_run_needs_exec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        draw_run_o |-> execute_on_o);

    // R8: the flag changes only after a register write or a read response
    p_exec_on_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we_i) && !$past(mem_rsp_valid_i)) |-> $stable(execute_on_o));
endmodule

bind query_cond_unit query_cond_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_we_i        (cfg_we_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_write_o (mem_req_write_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_wdata_o (mem_req_wdata_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .sem_valid_o     (sem_valid_o),
    .draw_ready_o    (draw_ready_o),
    .draw_run_o      (draw_run_o),
    .execute_on_o    (execute_on_o)
);

// File: tb/query_cond_unit_tb_top.sv
// Bench for query_cond_unit: a condition-mode vector table followed by
// directed query, stall, draw-gating and busy-trigger tests.
module query_cond_unit_tb_top;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [63:0] ts_cnt = 64'h1000_0000_0000_0000;
    logic        mem_req_valid, mem_req_write, mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        sem_valid;
    logic [31:0] sem_addr, sem_payload;
    logic        draw_req = 1'b0;
    logic        draw_ready, draw_run, execute_on;
    logic        stall_en = 1'b0;

    logic [31:0] mem [0:63];
    logic [31:0] wr_addr_log [0:7];
    logic [31:0] wr_data_log [0:7];
    logic [31:0] rd_addr_log [0:7];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    logic [63:0] cap_ts = '0;

    always #5 clk = ~clk;

    assign mem_req_ready = !stall_en || ts_cnt[0];

    query_cond_unit #(.ADDR_W(ADDR_W)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we_i        (cfg_we),
        .cfg_addr_i      (cfg_addr),
        .cfg_wdata_i     (cfg_wdata),
        .timestamp_i     (ts_cnt),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_ready_i (mem_req_ready),
        .mem_req_write_o (mem_req_write),
        .mem_req_addr_o  (mem_req_addr),
        .mem_req_wdata_o (mem_req_wdata),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_rdata_i (mem_rsp_rdata),
        .sem_valid_o     (sem_valid),
        .sem_addr_o      (sem_addr),
        .sem_payload_o   (sem_payload),
        .draw_req_i      (draw_req),
        .draw_ready_o    (draw_ready),
        .draw_run_o      (draw_run),
        .execute_on_o    (execute_on)
    );

    // Memory model: one-cycle read latency, logs writes and read addresses.
    always @(posedge clk) begin
        ts_cnt        <= ts_cnt + 64'd1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[7:2]] <= mem_req_wdata;
                if (wr_cnt < 8) begin
                    wr_addr_log[wr_cnt] <= mem_req_addr;
                    wr_data_log[wr_cnt] <= mem_req_wdata;
                end
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[7:2]];
                if (rd_cnt < 8) rd_addr_log[rd_cnt] <= mem_req_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        cap_ts    = ts_cnt;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_cond_done();
        while (!draw_ready) @(negedge clk);
    endtask

    task automatic clear_logs();
        @(negedge clk);
        wr_cnt = 0;
        rd_cnt = 0;
    endtask

    task automatic load_rec(input logic [31:0] a, b, c, d);
        mem[16] = a; mem[17] = b; mem[18] = c; mem[19] = d;
    endtask

    // Condition vector: mode, init_seq, init_mode, cur_seq, cur_mode, expected
    localparam int NV = 10;
    localparam logic [131:0] VTAB [NV] = '{
        {3'd0, 32'h0,      32'h0, 32'h0,      32'h0, 1'b0},
        {3'd1, 32'h0,      32'h0, 32'h0,      32'h0, 1'b1},
        {3'd2, 32'h5,      32'h0, 32'h0,      32'h0, 1'b0},
        {3'd2, 32'h5,      32'h7, 32'h0,      32'h0, 1'b1},
        {3'd2, 32'h0,      32'h3, 32'h0,      32'h0, 1'b0},
        {3'd3, 32'h9,      32'h2, 32'h9,      32'h2, 1'b1},
        {3'd3, 32'h9,      32'h2, 32'h9,      32'h3, 1'b0},
        {3'd4, 32'h9,      32'h2, 32'h9,      32'h3, 1'b1},
        {3'd4, 32'hA5A5,   32'h1, 32'hA5A5,   32'h1, 1'b0},
        {3'd7, 32'h0,      32'h0, 32'h0,      32'h0, 1'b1}
    };

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0, 3'd1: return "R7";
            3'd2:       return "R9";
            3'd3, 3'd4: return "R10";
            default:    return "R11";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 execute_on", execute_on, 1);
        chk("R1 draw_ready", draw_ready, 1);
        chk("R1 mem_req_valid", mem_req_valid, 0);
        chk("R1 sem_valid", sem_valid, 0);

        // Condition table walk
        cfg_write(3'd3, 32'h40);
        for (int i = 0; i < NV; i++) begin
            logic [131:0] v;
            v = VTAB[i];
            load_rec(v[128:97], v[96:65], v[64:33], v[32:1]);
            clear_logs();
            cfg_write(3'd4, {29'd0, v[131:129]});
            wait_cond_done();
            chk(mode_tag(v[131:129]), execute_on, v[0]);
            if (!qc_pkg::qc_mode_reads(v[131:129]))
                chk("R7 no read", rd_cnt, 0);
        end

        // R8: read order and addresses of an equal-mode fetch
        load_rec(32'h1, 32'h2, 32'h1, 32'h2);
        clear_logs();
        cfg_write(3'd4, 32'd3);
        wait_cond_done();
        chk("R8 read count", rd_cnt, 4);
        for (int k = 0; k < 4; k++)
            chk("R8 read addr", rd_addr_log[k], 32'h40 + 4 * k);

        // R2: fenced release -> semaphore strobe
        cfg_write(3'd0, 32'h100);
        cfg_write(3'd1, 32'hABCD_1234);
        clear_logs();
        cfg_write(3'd2, 32'h0000_0010);
        chk("R2 sem_valid", sem_valid, 1);
        chk("R2 sem_addr", sem_addr, 32'h100);
        chk("R2 sem_payload", sem_payload, 32'hABCD_1234);
        @(negedge clk);
        chk("R2 sem one cycle", sem_valid, 0);
        repeat (6) @(negedge clk);
        chk("R2 no write", wr_cnt, 0);

        // R3: short release
        clear_logs();
        cfg_write(3'd2, 32'h0000_0020);
        repeat (8) @(negedge clk);
        chk("R3 write count", wr_cnt, 1);
        chk("R3 addr", wr_addr_log[0], 32'h100);
        chk("R3 data", wr_data_log[0], 32'hABCD_1234);

        // R4 / R14: long release with a stalling port
        stall_en = 1'b1;
        clear_logs();
        cfg_write(3'd2, 32'h0000_0000);
        repeat (14) @(negedge clk);
        stall_en = 1'b0;
        chk("R4 write count", wr_cnt, 4);
        for (int k = 0; k < 4; k++)
            chk("R4 addr", wr_addr_log[k], 32'h100 + 4 * k);
        chk("R4 value lo", wr_data_log[0], 32'hABCD_1234);
        chk("R4 value hi", wr_data_log[1], 32'h0);
        chk("R4 ts lo", wr_data_log[2], cap_ts[31:0]);
        chk("R4 ts hi", wr_data_log[3], cap_ts[63:32]);
        chk("R14 data kept", mem[6'h00 + (32'h100 >> 2) % 64], 32'hABCD_1234);

        // R5: counter with select zero (short) and select 5 (long)
        clear_logs();
        cfg_write(3'd2, 32'h0000_0022);
        repeat (8) @(negedge clk);
        chk("R5 sel0 count", wr_cnt, 1);
        chk("R5 sel0 data", wr_data_log[0], 32'd0);
        clear_logs();
        cfg_write(3'd2, 32'h0000_0502);
        repeat (10) @(negedge clk);
        chk("R5 sel5 count", wr_cnt, 4);
        chk("R5 sel5 value", wr_data_log[0], 32'd1);
        chk("R5 sel5 ts lo", wr_data_log[2], cap_ts[31:0]);

        // R6: acquire and trap do nothing
        clear_logs();
        cfg_write(3'd2, 32'h0000_0031);
        chk("R6 acquire sem", sem_valid, 0);
        repeat (4) @(negedge clk);
        cfg_write(3'd2, 32'h0000_0013);
        chk("R6 trap sem", sem_valid, 0);
        repeat (6) @(negedge clk);
        chk("R6 no write", wr_cnt, 0);

        // R12: draws stall during a fetch, then follow the flag
        cfg_write(3'd4, 32'd1);
        load_rec(32'h4, 32'h4, 32'h4, 32'h5);
        draw_req = 1'b1;
        cfg_write(3'd4, 32'd3);
        chk("R12 ready low", draw_ready, 0);
        chk("R12 run low while pending", draw_run, 0);
        wait_cond_done();
        chk("R12 run off", draw_run, 0);
        cfg_write(3'd4, 32'd1);
        chk("R12 run on", draw_run, 1);
        draw_req = 1'b0;
        @(negedge clk);
        chk("R12 no req no run", draw_run, 0);

        // R13: trigger during a record fetch is ignored
        load_rec(32'h4, 32'h4, 32'h4, 32'h5);
        clear_logs();
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'd4;
        @(negedge clk);
        cfg_addr = 3'd2; cfg_wdata = 32'h0000_0020;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_cond_done();
        repeat (6) @(negedge clk);
        chk("R13 query ignored", wr_cnt, 0);
        chk("R13 fetch result", execute_on, 1);

        // R13: mode write while a long query runs is ignored
        clear_logs();
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 32'h0000_0000;
        @(negedge clk);
        cfg_addr = 3'd4; cfg_wdata = 32'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (8) @(negedge clk);
        chk("R13 mode ignored", execute_on, 1);
        chk("R13 query done", wr_cnt, 4);

        finish_run();
    end
endmodule